// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block sequences the row scan of a multiplexed dot-matrix LCD. A slow scan strobe (one pulse per row time, about 2 kHz in a real panel) advances a common counter. The counter plus a programmable top-line offset gives the display-memory row to fetch. On each strobe the fetched 80-bit row is captured into a holding register and shown on the segment outputs while the matching common output is selected. The duty can be 1/16 or 1/32.

The frame (AC inversion) signal flips the polarity of every segment and common output. A master unit generates the frame signal itself and toggles it each time the scan wraps to row zero. A slave unit takes the frame signal from outside, synchronises it, and restarts its scan on every change it sees.

The mode inputs can mirror the segment order, blank the panel, force every dot on, or, with forced-on and blanking combined, enter a power-save state that freezes the scan. The multi-level analog drive voltages are not modelled. Each segment and common is shown only as a select flag and a phase-corrected drive bit.

Top module: `lcd_scan_timing`

## Requirements
- R1: After reset the common counter is 0, the frame level is 0, the captured row is all zeros and the displayed row index is 0, so `ram_row` equals `start_line`.
- R2: `ram_row` is always (`start_line` + common count) modulo 32.
- R3: A `row_step` pulse captures `ram_data` into the row register, records the current count as the displayed row, and advances the count. The count returns to 0 after 15 when `duty32`=0 and after 31 when `duty32`=1, and any count at or above the active limit returns to 0.
- R4: In master mode (`master`=1), `frame_out` inverts on exactly the steps where the count wraps to 0, and holds at all other times.
- R5: In slave mode (`master`=0), `frame_out` follows `frame_in` two clock cycles after it changes. One cycle after that, the common count is forced to 0.
- R6: With `seg_reverse`=0, `seg_on[i]` is captured bit i. With `seg_reverse`=1 it is captured bit 79-i.
- R7: `seg_drv` = `seg_on` XOR `frame_out` for every bit, and `com_drv` = `com_sel` XOR `frame_out` for every bit, except in power save.
- R8: In normal display, `com_sel` has exactly one bit set, at the index of the displayed row.
- R9: With `disp_on`=0 and `static_drive`=0, `seg_on` and `com_sel` are all zero. The drive outputs then sit at the frame level, and the scan keeps advancing.
- R10: With `disp_on`=1 and `static_drive`=1, `seg_on` is all ones and the common scan continues normally.
- R11: With `disp_on`=0 and `static_drive`=1, `power_save`=1 and every drive output is 0. `row_step` is ignored, so the count and the master frame level do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_step | input | 1 | One-cycle pulse per row time |
| duty32 | input | 1 | 1 selects 1/32 duty, 0 selects 1/16 |
| start_line | input | 5 | Memory row shown on common 0 |
| seg_reverse | input | 1 | Mirror segment order |
| disp_on | input | 1 | Display enable |
| static_drive | input | 1 | Force all dots on |
| master | input | 1 | 1 generates the frame signal, 0 follows `frame_in` |
| frame_in | input | 1 | External frame signal in slave mode |
| ram_data | input | 80 | Memory data of row `ram_row` |
| ram_row | output | 5 | Memory row to fetch |
| frame_out | output | 1 | Active frame polarity |
| power_save | output | 1 | Power-save state active |
| seg_on | output | 80 | Segment select flags |
| seg_drv | output | 80 | Segment drive after polarity |
| com_sel | output | 32 | Common select flags |
| com_drv | output | 32 | Common drive after polarity |

## Verification
On every cycle, assertions check the following:
- the count stays within the 1/16 limit after a step;
- the master frame level holds except at a wrap;
- a slave resync clears the count;
- power save freezes the count;
- exactly one common is selected in normal display.

Only the bench scenarios can show the end-to-end behaviour:
- that the captured data is the row at `start_line` + count;
- that the mirrored segment order is correct;
- that blanking keeps the scan running;
- the exact cycle at which a slave frame change reaches the output and restarts the scan.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int DEF_SEGS = 80;
    localparam int DEF_COMS = 32;

    typedef enum logic [1:0] {
        DM_NORMAL = 2'd0,
        DM_BLANK  = 2'd1,
        DM_ALLON  = 2'd2,
        DM_SAVE   = 2'd3
    } disp_mode_e;

    function automatic disp_mode_e mode_of(input logic on, input logic stat);
        if (!on && stat)  return DM_SAVE;
        if (!on)          return DM_BLANK;
        if (stat)         return DM_ALLON;
        return DM_NORMAL;
    endfunction

endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int COMS = lcd_scan_pkg::DEF_COMS,
    localparam int RW = $clog2(COMS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          freeze,
    input  logic          duty32,
    input  logic          master,
    input  logic          frame_in,
    output logic [RW-1:0] cnt,
    output logic          frame
);
    localparam logic [RW-1:0] LAST_FULL = RW'(COMS - 1);
    localparam logic [RW-1:0] LAST_HALF = RW'(COMS / 2 - 1);

    logic [2:0]    fr_sync;
    logic          frame_q;
    logic          adv, wrap, resync;
    logic [RW-1:0] last;

    assign last   = duty32 ? LAST_FULL : LAST_HALF;
    assign wrap   = (cnt >= last);
    assign adv    = step && !freeze;
    assign resync = !master && (fr_sync[1] ^ fr_sync[2]);
    assign frame  = master ? frame_q : fr_sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            frame_q <= 1'b0;
            fr_sync <= '0;
        end else begin
            fr_sync <= {fr_sync[1:0], frame_in};
            if (resync)
                cnt <= '0;
            else if (adv)
                cnt <= wrap ? '0 : cnt + 1'b1;
            if (master && adv && wrap)
                frame_q <= ~frame_q;
        end
    end

    // R3
    duty16_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !duty32) |=> (cnt <= LAST_HALF));

    // R4
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (master && !(adv && wrap)) |=> $stable(frame_q));

    // R5
    resync_zero_chk: assert property (@(posedge clk) disable iff (rst)
        resync |=> (cnt == '0));

    // R11
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !resync) |=> $stable(cnt));

endmodule

// File: rtl/row_latch.sv
module row_latch #(
    parameter int SEGS = lcd_scan_pkg::DEF_SEGS,
    parameter int COMS = lcd_scan_pkg::DEF_COMS,
    localparam int RW = $clog2(COMS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [SEGS-1:0] row_bits,
    input  logic [RW-1:0]   row_idx,
    output logic [SEGS-1:0] held_bits,
    output logic [RW-1:0]   held_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_bits <= '0;
            held_idx  <= '0;
        end else if (load) begin
            held_bits <= row_bits;
            held_idx  <= row_idx;
        end
    end
endmodule

// File: rtl/drive_mapper.sv
module drive_mapper
    import lcd_scan_pkg::*;
#(
    parameter int SEGS = lcd_scan_pkg::DEF_SEGS,
    parameter int COMS = lcd_scan_pkg::DEF_COMS,
    localparam int RW = $clog2(COMS)
) (
    input  disp_mode_e      mode,
    input  logic            reverse,
    input  logic            frame,
    input  logic [SEGS-1:0] held_bits,
    input  logic [RW-1:0]   held_idx,
    output logic [SEGS-1:0] seg_on,
    output logic [SEGS-1:0] seg_drv,
    output logic [COMS-1:0] com_sel,
    output logic [COMS-1:0] com_drv
);
    logic [SEGS-1:0] ordered;
    logic [COMS-1:0] decoded;

    for (genvar s = 0; s < SEGS; s++) begin : g_order
        assign ordered[s] = reverse ? held_bits[SEGS-1-s] : held_bits[s];
    end

    for (genvar c = 0; c < COMS; c++) begin : g_dec
        assign decoded[c] = (held_idx == RW'(c));
    end

    always_comb begin
        unique case (mode)
            DM_NORMAL: begin seg_on = ordered;     com_sel = decoded; end
            DM_ALLON:  begin seg_on = '1;          com_sel = decoded; end
            default:   begin seg_on = '0;          com_sel = '0;      end
        endcase
        if (mode == DM_SAVE) begin
            seg_drv = '0;
            com_drv = '0;
        end else begin
            seg_drv = seg_on  ^ {SEGS{frame}};
            com_drv = com_sel ^ {COMS{frame}};
        end
    end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int SEGS = lcd_scan_pkg::DEF_SEGS,
    parameter int COMS = lcd_scan_pkg::DEF_COMS,
    localparam int RW = $clog2(COMS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            row_step,
    input  logic            duty32,
    input  logic [RW-1:0]   start_line,
    input  logic            seg_reverse,
    input  logic            disp_on,
    input  logic            static_drive,
    input  logic            master,
    input  logic            frame_in,
    input  logic [SEGS-1:0] ram_data,
    output logic [RW-1:0]   ram_row,
    output logic            frame_out,
    output logic            power_save,
    output logic [SEGS-1:0] seg_on,
    output logic [SEGS-1:0] seg_drv,
    output logic [COMS-1:0] com_sel,
    output logic [COMS-1:0] com_drv
);
    disp_mode_e      mode;
    logic [RW-1:0]   cnt;
    logic [RW-1:0]   held_idx;
    logic [SEGS-1:0] held_bits;
    logic            load;

    assign mode       = mode_of(disp_on, static_drive);
    assign power_save = (mode == DM_SAVE);
    assign load       = row_step && !power_save;
    assign ram_row    = start_line + cnt;

    scan_counter #(.COMS(COMS)) u_cnt (
        .clk(clk), .rst(rst), .step(row_step), .freeze(power_save),
        .duty32(duty32), .master(master), .frame_in(frame_in),
        .cnt(cnt), .frame(frame_out)
    );

    row_latch #(.SEGS(SEGS), .COMS(COMS)) u_latch (
        .clk(clk), .rst(rst), .load(load), .row_bits(ram_data),
        .row_idx(cnt), .held_bits(held_bits), .held_idx(held_idx)
    );

    drive_mapper #(.SEGS(SEGS), .COMS(COMS)) u_map (
        .mode(mode), .reverse(seg_reverse), .frame(frame_out),
        .held_bits(held_bits), .held_idx(held_idx),
        .seg_on(seg_on), .seg_drv(seg_drv), .com_sel(com_sel), .com_drv(com_drv)
    );

    // R8
    one_common_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == DM_NORMAL || mode == DM_ALLON) |-> ($countones(com_sel) == 1));

    // R11
    save_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        power_save |-> ($countones(seg_drv) == 0 && $countones(com_drv) == 0));

    // R9
    blank_level_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == DM_BLANK) |-> ($countones(seg_drv) == (frame_out ? SEGS : 0)));

endmodule

// File: tb/lcd_scan_timing_test.sv
module lcd_scan_timing_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        row_step = 0;
    logic        duty32 = 0;
    logic [4:0]  start_line = 0;
    logic        seg_reverse = 0;
    logic        disp_on = 1;
    logic        static_drive = 0;
    logic        master = 1;
    logic        frame_in = 0;
    logic [79:0] ram_data;
    logic [4:0]  ram_row;
    logic        frame_out, power_save;
    logic [79:0] seg_on, seg_drv;
    logic [31:0] com_sel, com_drv;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          m_cnt = 0;
    int          m_act = 0;
    logic [79:0] m_lat = '0;
    logic        m_fr = 0;
    logic        m_sfr = 0;

    always #4 clk = ~clk;

    lcd_scan_timing uut (
        .clk(clk), .rst(rst), .row_step(row_step), .duty32(duty32),
        .start_line(start_line), .seg_reverse(seg_reverse), .disp_on(disp_on),
        .static_drive(static_drive), .master(master), .frame_in(frame_in),
        .ram_data(ram_data), .ram_row(ram_row), .frame_out(frame_out),
        .power_save(power_save), .seg_on(seg_on), .seg_drv(seg_drv),
        .com_sel(com_sel), .com_drv(com_drv)
    );

    function automatic logic [79:0] pat(input logic [4:0] r);
        logic [10:0] hi;
        hi = 11'(r) * 11'd37 + 11'd5;
        return {5{hi, r}};
    endfunction

    always_comb ram_data = pat(ram_row);

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_frame();
        return master ? m_fr : m_sfr;
    endfunction

    function automatic logic [79:0] exp_seg_on();
        logic [79:0] m;
        if (!disp_on) return '0;
        if (static_drive) return '1;
        for (int i = 0; i < 80; i++) m[i] = seg_reverse ? m_lat[79-i] : m_lat[i];
        return m;
    endfunction

    function automatic logic [31:0] exp_com_sel();
        if (!disp_on) return '0;
        return 32'(1) << m_act;
    endfunction

    task automatic check_all();
        logic ps;
        ps = !disp_on && static_drive;
        chk("R2 ram_row", 80'(ram_row), 80'(5'(start_line + 5'(m_cnt))));
        chk("R4 R5 frame_out", 80'(frame_out), 80'(exp_frame()));
        chk("R11 power_save", 80'(power_save), 80'(ps));
        if (ps) begin
            chk("R11 seg_drv", seg_drv, '0);
            chk("R11 com_drv", 80'(com_drv), '0);
        end else begin
            chk("R6 R9 R10 seg_on", seg_on, exp_seg_on());
            chk("R8 R9 com_sel", 80'(com_sel), 80'(exp_com_sel()));
            chk("R7 seg_drv", seg_drv, exp_seg_on() ^ {80{exp_frame()}});
            chk("R7 com_drv", 80'(com_drv), 80'(exp_com_sel() ^ {32{exp_frame()}}));
        end
    endtask

    // R3 reference step model
    task automatic step();
        int last;
        @(negedge clk);
        row_step = 1;
        @(posedge clk);
        if (!(!disp_on && static_drive)) begin
            m_lat = pat(5'(start_line + 5'(m_cnt)));
            m_act = m_cnt;
            last  = duty32 ? 31 : 15;
            if (m_cnt >= last) begin
                m_cnt = 0;
                if (master) m_fr = !m_fr;
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
        row_step = 0;
        check_all();
    endtask

    task automatic slave_edge();
        @(negedge clk);
        frame_in = !frame_in;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R5 frame follows", 80'(frame_out), 80'(frame_in));
        chk("R5 count not yet cleared", 80'(ram_row), 80'(5'(start_line + 5'(m_cnt))));
        @(posedge clk);
        @(negedge clk);
        m_sfr = frame_in;
        m_cnt = 0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1207));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 ram_row", 80'(ram_row), 80'd0);
        chk("R1 frame_out", 80'(frame_out), 80'd0);
        chk("R1 seg_on", seg_on, '0);
        chk("R1 com_sel", 80'(com_sel), 80'd1);
        check_all();

        // R3 R4 1/16 duty wrap and frame toggle
        for (int i = 0; i < 34; i++) step();
        // R3 1/32 duty
        duty32 = 1;
        for (int i = 0; i < 40; i++) step();
        // R2 start offsets with modulo
        start_line = 5'd7;
        for (int i = 0; i < 10; i++) step();
        start_line = 5'd29;
        for (int i = 0; i < 10; i++) step();
        // R6 reversed order
        seg_reverse = 1;
        for (int i = 0; i < 6; i++) step();
        seg_reverse = 0;
        // R9 blanking keeps scanning
        disp_on = 0;
        for (int i = 0; i < 5; i++) step();
        disp_on = 1;
        #1 check_all();
        // R10 all dots on
        static_drive = 1;
        for (int i = 0; i < 4; i++) step();
        // R11 power save ignores steps
        disp_on = 0;
        for (int i = 0; i < 40; i++) step();
        disp_on = 1;
        static_drive = 0;
        step();
        // R3 duty shrink while count above 15
        duty32 = 1;
        while (m_cnt < 20) step();
        duty32 = 0;
        step();
        chk("R3 shrink wrap", 80'(ram_row), 80'(start_line));

        // random mix in master mode
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                duty32       = 1'($urandom);
                start_line   = 5'($urandom);
                seg_reverse  = 1'($urandom);
                disp_on      = ($urandom_range(0, 3) != 0);
                static_drive = ($urandom_range(0, 3) == 0);
            end
            step();
        end
        disp_on = 1;
        static_drive = 0;

        // R5 slave mode
        @(negedge clk);
        master = 0;
        m_sfr = frame_in;
        #1 check_all();
        for (int i = 0; i < 5; i++) step();
        slave_edge();
        for (int i = 0; i < 7; i++) step();
        slave_edge();
        step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule